// File: doc/BRIEF.md
# Two-Subphase Request Address Parity Unit

This block produces and verifies the two address-parity bits that accompany a bus request. A request is transferred in two subphases. Each one carries the active-low address bits 37 to 3 and a 5-bit active-low request-type code. The two parity bits each cover one of two signal groups. The upper group is address bits 37 to 24. The lower group is address bits 23 to 3 together with the request-type code. Which parity bit covers which group depends on the subphase.

The block has two independent halves. The initiator half takes the request bits that are about to be driven, along with a subphase select, and registers the two parity pins one bus clock later. The observer half takes sampled request bits and the received parity pins under a valid qualifier. It recomputes parity and reports a one-cycle error pulse for each parity bit. It also keeps a sticky flag for each bit until software logic clears it.

Every value on the ports is a pin level. A parity pin is high when an even number of the signals it covers are low, so a fully idle bus (all high) carries high parity.

The initiator half is a two-state machine. GEN_IDLE drives both parity pins high. GEN_DRIVE drives the captured parity. The transition IDLE→DRIVE or DRIVE→DRIVE is taken when `gen_valid` is sampled high, and DRIVE→IDLE or IDLE→IDLE when it is low.

Each sticky flag is a two-state machine. FLAG_CLEAN goes to FLAG_HELD on a mismatch. FLAG_HELD returns to FLAG_CLEAN on `err_clr` when no mismatch arrives in the same cycle. Otherwise it stays in FLAG_HELD.

Top module: `addr_parity_unit`

## Requirements
- R1: A parity pin is 1 when the count of low signals in its covered group is even and 0 when the count is odd. With every covered signal high, both pins are 1.
- R2: With subphase select 0, parity pin bit 0 covers address bits 37..24. Pin bit 1 covers address bits 23..3 plus the 5 request-type bits.
- R3: With subphase select 1, the mapping swaps. Pin bit 1 covers address bits 37..24, and pin bit 0 covers address bits 23..3 plus the request-type bits.
- R4: `gen_par_n` shows the parity of the inputs sampled at a rising edge, from that edge until the next one, when `gen_valid` was high. When `gen_valid` was low at that edge, it shows 2'b11.
- R5: When `chk_valid` is high at an edge, each bit of `err_pulse` is 1 for the following cycle exactly when the received parity bit differs from the recomputed bit. The two bits are independent.
- R6: When `chk_valid` is low at an edge, `err_pulse` is 2'b00 for the following cycle, whatever the received parity.
- R7: A bit of `err_sticky` becomes 1 together with its error pulse. It stays 1 through later clean or unqualified cycles until a clear.
- R8: `err_clr` high at an edge clears both sticky bits. A mismatch sampled at the same edge keeps its sticky bit set.
- R9: Synchronous active-high `rst` sets `gen_par_n` to 2'b11 and clears `err_pulse` and `err_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all activity on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| gen_valid | input | 1 | Initiator request strobe for this subphase |
| gen_sub | input | 1 | Initiator subphase select (0 or 1) |
| gen_addr_n | input | 35 | Initiator address pins 37..3, active low |
| gen_req_n | input | 5 | Initiator request-type pins, active low |
| gen_par_n | output | 2 | Registered parity pins to drive |
| chk_valid | input | 1 | Observer qualifier for the sampled subphase |
| chk_sub | input | 1 | Observer subphase select (0 or 1) |
| chk_addr_n | input | 35 | Sampled address pins 37..3 |
| chk_req_n | input | 5 | Sampled request-type pins |
| chk_par_n | input | 2 | Sampled parity pins |
| err_clr | input | 1 | Clears both sticky error flags |
| err_pulse | output | 2 | One-cycle mismatch flag per parity bit |
| err_sticky | output | 2 | Held mismatch flag per parity bit |

## Verification
The hardest condition to reach is a sticky flag receiving a clear and a fresh mismatch at the same edge, where the set must win over the clear. The stimulus gets there by raising `err_clr` on a fixed stride through the sweep while the received parity is corrupted by every 2-bit flip pattern, so clears land both on clean cycles and on cycles that carry errors. The mapping swap is reached by walking a single low bit across all 40 covered signals in both subphases, which shows any misrouted group bit on the wrong pin.

// File: rtl/apu_pkg.sv
package apu_pkg;

    typedef enum logic {
        SUB_A = 1'b0,
        SUB_B = 1'b1
    } subphase_e;

    typedef enum logic {
        GEN_IDLE  = 1'b0,
        GEN_DRIVE = 1'b1
    } gen_state_e;

    typedef enum logic {
        FLAG_CLEAN = 1'b0,
        FLAG_HELD  = 1'b1
    } flag_state_e;

    localparam logic [1:0] PAR_IDLE = 2'b11;

endpackage

// File: rtl/apu_cover.sv
module apu_cover #(
    parameter int ADDR_HI = 37,
    parameter int ADDR_LO = 3,
    parameter int SPLIT   = 24,
    parameter int REQ_W   = 5
) (
    input  logic [ADDR_HI:ADDR_LO] addr_n,
    input  logic [REQ_W-1:0]       req_n,
    input  logic                   sub,
    output logic [1:0]             par_n
);
    import apu_pkg::*;

    localparam int HI_W = ADDR_HI - SPLIT + 1;
    localparam int LO_W = SPLIT - ADDR_LO + REQ_W;

    logic [HI_W-1:0] hi_grp;
    logic [LO_W-1:0] lo_grp;
    logic            hi_pin;
    logic            lo_pin;
    subphase_e       sel;

    always_comb begin
        hi_grp = addr_n[ADDR_HI:SPLIT];
        lo_grp = {addr_n[SPLIT-1:ADDR_LO], req_n};
        // pin is high when the count of low signals is even
        hi_pin = ~(^(~hi_grp));
        lo_pin = ~(^(~lo_grp));
        sel    = subphase_e'(sub);
    end

    always_comb begin
        unique case (sel)
            SUB_A:   par_n = {lo_pin, hi_pin};
            SUB_B:   par_n = {hi_pin, lo_pin};
            default: par_n = PAR_IDLE;
        endcase
    end

endmodule

// File: rtl/apu_gen.sv
module apu_gen #(
    parameter int ADDR_HI = 37,
    parameter int ADDR_LO = 3,
    parameter int SPLIT   = 24,
    parameter int REQ_W   = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   valid,
    input  logic                   sub,
    input  logic [ADDR_HI:ADDR_LO] addr_n,
    input  logic [REQ_W-1:0]       req_n,
    output logic [1:0]             par_n
);
    import apu_pkg::*;

    gen_state_e state_q, state_d;
    logic [1:0] cov_par;
    logic [1:0] par_q;

    apu_cover #(
        .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .SPLIT(SPLIT), .REQ_W(REQ_W)
    ) u_cover (
        .addr_n(addr_n),
        .req_n (req_n),
        .sub   (sub),
        .par_n (cov_par)
    );

    always_comb begin
        unique case (state_q)
            GEN_IDLE:  state_d = valid ? GEN_DRIVE : GEN_IDLE;
            GEN_DRIVE: state_d = valid ? GEN_DRIVE : GEN_IDLE;
            default:   state_d = GEN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GEN_IDLE;
            par_q   <= PAR_IDLE;
        end else begin
            state_q <= state_d;
            if (valid) par_q <= cov_par;
        end
    end

    always_comb begin
        unique case (state_q)
            GEN_IDLE:  par_n = PAR_IDLE;
            GEN_DRIVE: par_n = par_q;
            default:   par_n = PAR_IDLE;
        endcase
    end

endmodule

// File: rtl/apu_flag.sv
module apu_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic held
);
    import apu_pkg::*;

    flag_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            FLAG_CLEAN: state_d = set ? FLAG_HELD : FLAG_CLEAN;
            FLAG_HELD:  state_d = (clr && !set) ? FLAG_CLEAN : FLAG_HELD;
            default:    state_d = FLAG_CLEAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FLAG_CLEAN;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FLAG_CLEAN: held = 1'b0;
            FLAG_HELD:  held = 1'b1;
            default:    held = 1'b0;
        endcase
    end

endmodule

// File: rtl/apu_chk.sv
module apu_chk #(
    parameter int ADDR_HI = 37,
    parameter int ADDR_LO = 3,
    parameter int SPLIT   = 24,
    parameter int REQ_W   = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   valid,
    input  logic                   sub,
    input  logic [ADDR_HI:ADDR_LO] addr_n,
    input  logic [REQ_W-1:0]       req_n,
    input  logic [1:0]             rx_par_n,
    input  logic                   clr,
    output logic [1:0]             pulse,
    output logic [1:0]             sticky
);
    logic [1:0] cov_par;
    logic [1:0] mismatch;

    apu_cover #(
        .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .SPLIT(SPLIT), .REQ_W(REQ_W)
    ) u_cover (
        .addr_n(addr_n),
        .req_n (req_n),
        .sub   (sub),
        .par_n (cov_par)
    );

    always_comb mismatch = (cov_par ^ rx_par_n) & {2{valid}};

    always_ff @(posedge clk) begin
        if (rst) pulse <= 2'b00;
        else     pulse <= mismatch;
    end

    for (genvar b = 0; b < 2; b++) begin : g_flag
        apu_flag u_flag (
            .clk (clk),
            .rst (rst),
            .set (mismatch[b]),
            .clr (clr),
            .held(sticky[b])
        );
    end

endmodule

// File: rtl/addr_parity_unit.sv
module addr_parity_unit #(
    parameter int ADDR_HI = 37,
    parameter int ADDR_LO = 3,
    parameter int SPLIT   = 24,
    parameter int REQ_W   = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   gen_valid,
    input  logic                   gen_sub,
    input  logic [ADDR_HI:ADDR_LO] gen_addr_n,
    input  logic [REQ_W-1:0]       gen_req_n,
    output logic [1:0]             gen_par_n,
    input  logic                   chk_valid,
    input  logic                   chk_sub,
    input  logic [ADDR_HI:ADDR_LO] chk_addr_n,
    input  logic [REQ_W-1:0]       chk_req_n,
    input  logic [1:0]             chk_par_n,
    input  logic                   err_clr,
    output logic [1:0]             err_pulse,
    output logic [1:0]             err_sticky
);

    apu_gen #(
        .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .SPLIT(SPLIT), .REQ_W(REQ_W)
    ) u_gen (
        .clk   (clk),
        .rst   (rst),
        .valid (gen_valid),
        .sub   (gen_sub),
        .addr_n(gen_addr_n),
        .req_n (gen_req_n),
        .par_n (gen_par_n)
    );

    apu_chk #(
        .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .SPLIT(SPLIT), .REQ_W(REQ_W)
    ) u_chk (
        .clk     (clk),
        .rst     (rst),
        .valid   (chk_valid),
        .sub     (chk_sub),
        .addr_n  (chk_addr_n),
        .req_n   (chk_req_n),
        .rx_par_n(chk_par_n),
        .clr     (err_clr),
        .pulse   (err_pulse),
        .sticky  (err_sticky)
    );

endmodule

// File: rtl/apu_checks.sv
module apu_checks (
    input logic       clk,
    input logic       rst,
    input logic       gen_valid,
    input logic [1:0] gen_par_n,
    input logic       chk_valid,
    input logic       err_clr,
    input logic [1:0] err_pulse,
    input logic [1:0] err_sticky
);

    // R4: an unqualified initiator cycle leaves the pins idle high
    p_idle_high_r4: assert property (@(posedge clk) disable iff (rst)
        !gen_valid |=> gen_par_n == 2'b11);

    // R6: no error pulse after an unqualified observer cycle
    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> err_pulse == 2'b00);

    // R7: a pulse is always accompanied by its sticky bit
    p_pulse_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (err_pulse & ~err_sticky) == 2'b00);

    // R7: without a clear, sticky bits never drop
    p_sticky_keep_r7: assert property (@(posedge clk) disable iff (rst)
        !err_clr |=> (err_sticky & $past(err_sticky)) == $past(err_sticky));

    // R8: after a clear only freshly flagged bits remain
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> (err_sticky & ~err_pulse) == 2'b00);

endmodule

bind addr_parity_unit apu_checks u_apu_checks (
    .clk       (clk),
    .rst       (rst),
    .gen_valid (gen_valid),
    .gen_par_n (gen_par_n),
    .chk_valid (chk_valid),
    .err_clr   (err_clr),
    .err_pulse (err_pulse),
    .err_sticky(err_sticky)
);

// File: tb/sim_addr_parity_unit.sv
`timescale 1ns/1ps
module sim_addr_parity_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gen_valid = 1'b0, gen_sub = 1'b0;
    logic [37:3] gen_addr_n = '1;
    logic [4:0]  gen_req_n = '1;
    logic [1:0]  gen_par_n;
    logic        chk_valid = 1'b0, chk_sub = 1'b0;
    logic [37:3] chk_addr_n = '1;
    logic [4:0]  chk_req_n = '1;
    logic [1:0]  chk_par_n = 2'b11;
    logic        err_clr = 1'b0;
    logic [1:0]  err_pulse, err_sticky;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    logic [1:0] exp_sticky = 2'b00;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #5 clk = ~clk;

    addr_parity_unit u0 (
        .clk(clk), .rst(rst),
        .gen_valid(gen_valid), .gen_sub(gen_sub), .gen_addr_n(gen_addr_n),
        .gen_req_n(gen_req_n), .gen_par_n(gen_par_n),
        .chk_valid(chk_valid), .chk_sub(chk_sub), .chk_addr_n(chk_addr_n),
        .chk_req_n(chk_req_n), .chk_par_n(chk_par_n),
        .err_clr(err_clr), .err_pulse(err_pulse), .err_sticky(err_sticky)
    );

    // expected pin parity: count lows per group, high on even count
    function automatic logic [1:0] exp_par(logic [37:3] a, logic [4:0] r, logic s);
        int hi_lows = 0;
        int lo_lows = 0;
        logic ph, pl;
        for (int i = 24; i <= 37; i++) if (a[i] == 1'b0) hi_lows++;
        for (int i = 3; i <= 23; i++)  if (a[i] == 1'b0) lo_lows++;
        for (int i = 0; i < 5; i++)    if (r[i] == 1'b0) lo_lows++;
        ph = (hi_lows % 2 == 0);
        pl = (lo_lows % 2 == 0);
        return s ? {ph, pl} : {pl, ph};
    endfunction

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive one cycle from a negedge, sample at the following negedge
    task automatic step(logic [37:3] a, logic [4:0] r, logic s, logic gv,
                        logic cv, logic [1:0] flip, logic clr, string tag);
        logic [1:0] p;
        logic [1:0] miss;
        p = exp_par(a, r, s);
        gen_valid = gv; gen_sub = s; gen_addr_n = a; gen_req_n = r;
        chk_valid = cv; chk_sub = s; chk_addr_n = a; chk_req_n = r;
        chk_par_n = p ^ flip; err_clr = clr;
        @(negedge clk);
        miss = cv ? flip : 2'b00;
        exp_sticky = (clr ? 2'b00 : exp_sticky) | miss;
        check(gv ? tag : "R4", gen_par_n, gv ? p : 2'b11);
        check(cv ? "R5" : "R6", err_pulse, miss);
        check(clr ? "R8" : "R7", err_sticky, exp_sticky);
    endtask

    function automatic logic [63:0] next_rand(logic [63:0] x);
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state, with activity presented during reset
        gen_valid = 1'b1; gen_addr_n = '0; chk_valid = 1'b1; chk_par_n = 2'b00;
        @(negedge clk);
        check("R9", gen_par_n, 2'b11);
        check("R9", err_pulse, 2'b00);
        check("R9", err_sticky, 2'b00);
        rst = 1'b0;

        // R1: all high and all low buses
        step('1, '1, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, "R1");
        step('0, '0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, "R1");

        // R1, R2, R3: walking single low over all covered signals, both subphases
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 40; k++) begin
                logic [39:0] v;
                v = ~(40'd1 << k);
                step(v[39:5], v[4:0], s[0], 1'b1, 1'b1, 2'b00, 1'b0,
                     s[0] ? "R3" : "R2");
            end
        end

        // R5, R7, R8: every flip pattern, clears on a stride, both subphases
        for (int n = 0; n < 200; n++) begin
            logic [63:0] rv;
            seed = next_rand(seed);
            rv = seed;
            step(rv[39:5], rv[44:40], rv[50], rv[51] | (n < 100),
                 rv[52] | (n < 120), rv[54:53], (n % 7) == 3,
                 rv[50] ? "R3" : "R2");
        end

        // R7: sticky holds through clean and unqualified cycles
        step('1, '1, 1'b0, 1'b1, 1'b1, 2'b10, 1'b1, "R2");
        for (int n = 0; n < 4; n++)
            step('1, '1, 1'b1, 1'b0, n[0], 2'b11 & {2{~n[0]}}, 1'b0, "R3");
        // R8: clear coinciding with a fresh mismatch on the other bit
        step('1, '1, 1'b1, 1'b1, 1'b1, 2'b01, 1'b1, "R3");
        step('1, '1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1, "R3");
        // R6: corrupted parity ignored while unqualified
        step('0, '1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, "R2");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule